// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural floating-point register, the identity of the reservation station that will deliver that register's next value, next to the register's last committed value. A tag of zero means no write is outstanding, and the register value is then current. Instructions issue one at a time in program order. For each of the two source registers the table returns either the value, with tag zero, or the nonzero tag of the pending producer, with value zero. In the same cycle it records the issuing station's tag as the new producer of the destination register. A later writer overwrites the entry, so write-after-write and write-after-read cases never stall.

The table also watches the shared result broadcast bus, which carries a 64-bit value and a 4-bit producer tag. Every register whose recorded producer equals the bus tag takes the bus value, and its entry is cleared. An issuing instruction that reads a register whose producer is broadcasting in that same cycle is given the bus value directly, with tag zero.

Top module: `rename_status_table`

## Requirements
- R1: While reset is asserted, every status entry becomes zero and every stored value becomes zero. After reset, each register reads back as value 0 with tag 0.
- R2: Reading a source whose status entry is zero returns the stored value on the value output and zero on the tag output, with no cycle of delay.
- R3: Reading a source whose status entry is nonzero, and whose tag is not on the bus in that cycle, returns that tag on the tag output and zero on the value output.
- R4: An issue with a nonzero station tag writes that tag into the destination entry, visible from the next cycle. A later issue to the same destination overwrites it.
- R5: A valid broadcast with a nonzero tag writes the bus data into every register whose entry equals that tag and clears those entries, visible from the next cycle.
- R6: A broadcast with the valid input low, or with tag zero, changes no entry and no value.
- R7: When a broadcast clears a register in the same cycle that an issue renames it, the entry holds the new issuing tag afterwards.
- R8: A source read whose entry equals the tag of a valid broadcast in the same cycle returns the bus data with tag zero.
- R9: An issue with the valid input low, or with station tag zero, leaves every entry unchanged.
- R10: Source reads see the table as it stood before the same cycle's issue, so a source equal to the destination returns the older producer or value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 3 | First source register index |
| iss_src_b | input | 3 | Second source register index |
| iss_dst | input | 3 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station (nonzero) |
| bus_valid | input | 1 | Broadcast bus carries a result |
| bus_tag | input | 4 | Producer tag on the broadcast bus |
| bus_data | input | 64 | Result value on the broadcast bus |
| rd_a_val | output | 64 | First source value, zero while pending |
| rd_a_tag | output | 4 | First source producer tag, zero when ready |
| rd_b_val | output | 64 | Second source value, zero while pending |
| rd_b_tag | output | 4 | Second source producer tag, zero when ready |

## Verification
A corrupted status entry shows up at the next read of that register as a wrong tag or a value that should not be there. The read ports are combinational, so a fault caused by an issue or a broadcast is visible one cycle later, whenever any source selects the damaged register. A missed tag match leaves the register pending forever. A false match puts foreign data into a register that another station still owns. Mixing random traffic with reads of both sources every cycle brings out either fault within a few cycles.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // How a source operand is delivered at issue
  typedef enum logic [1:0] {
    SRC_READY   = 2'd0,
    SRC_PENDING = 2'd1,
    SRC_BYPASS  = 2'd2
  } src_kind_e;

  // Decide the delivery kind from "entry busy" and "entry matches bus"
  function automatic src_kind_e classify(input logic busy, input logic on_bus);
    if (!busy)      return SRC_READY;
    else if (on_bus) return SRC_BYPASS;
    else             return SRC_PENDING;
  endfunction

endpackage

// File: rtl/rrs_entry.sv
module rrs_entry #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rename_i,
  input  logic [TAG_W-1:0]  new_tag_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o,
  output logic              hit_o
);

  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;

  // Entry owns a pending write and the bus is delivering it now
  assign hit_o = bus_valid_i && (bus_tag_i != '0) && (tag_q == bus_tag_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else begin
      if (hit_o) val_q <= bus_data_i;
      if (rename_i)   tag_q <= new_tag_i;
      else if (hit_o) tag_q <= '0;
    end
  end

  assign tag_o = tag_q;
  assign val_o = val_q;

endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 3
) (
  input  logic [IDX_W-1:0]                 src_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_tbl_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_tbl_i,
  input  logic                             bus_valid_i,
  input  logic [TAG_W-1:0]                 bus_tag_i,
  input  logic [DATA_W-1:0]                bus_data_i,
  output logic [DATA_W-1:0]                val_o,
  output logic [TAG_W-1:0]                 tag_o,
  output src_kind_e                        kind_o
);

  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;
  logic              sel_on_bus;

  always_comb begin
    sel_tag = '0;
    sel_val = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (src_i == IDX_W'(r)) begin
        sel_tag = tag_tbl_i[r];
        sel_val = val_tbl_i[r];
      end
    end
  end

  assign sel_on_bus = bus_valid_i && (sel_tag == bus_tag_i);
  assign kind_o     = classify(sel_tag != '0, sel_on_bus);

  always_comb begin
    unique case (kind_o)
      SRC_READY:   begin val_o = sel_val;    tag_o = '0;      end
      SRC_BYPASS:  begin val_o = bus_data_i; tag_o = '0;      end
      default:     begin val_o = '0;         tag_o = sel_tag; end
    endcase
  end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] rd_a_val,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_b_val,
  output logic [TAG_W-1:0]  rd_b_tag
);

  // Named internal events, brought out for the checker
  logic                            issue_fire;
  logic [NUM_REGS-1:0]             rename_vec;
  logic [NUM_REGS-1:0]             bus_hit_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_tbl;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_tbl;
  rrs_pkg::src_kind_e              kind_a;
  rrs_pkg::src_kind_e              kind_b;

  assign issue_fire = iss_valid && (iss_tag != '0);

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      assign rename_vec[r] = issue_fire && (iss_dst == IDX_W'(r));
      rrs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .rename_i   (rename_vec[r]),
        .new_tag_i  (iss_tag),
        .bus_valid_i(bus_valid),
        .bus_tag_i  (bus_tag),
        .bus_data_i (bus_data),
        .tag_o      (tag_tbl[r]),
        .val_o      (val_tbl[r]),
        .hit_o      (bus_hit_vec[r])
      );
    end
  endgenerate

  rrs_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_port_a (
    .src_i      (iss_src_a),
    .tag_tbl_i  (tag_tbl),
    .val_tbl_i  (val_tbl),
    .bus_valid_i(bus_valid),
    .bus_tag_i  (bus_tag),
    .bus_data_i (bus_data),
    .val_o      (rd_a_val),
    .tag_o      (rd_a_tag),
    .kind_o     (kind_a)
  );

  rrs_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_port_b (
    .src_i      (iss_src_b),
    .tag_tbl_i  (tag_tbl),
    .val_tbl_i  (val_tbl),
    .bus_valid_i(bus_valid),
    .bus_tag_i  (bus_tag),
    .bus_data_i (bus_data),
    .val_o      (rd_b_val),
    .tag_o      (rd_b_tag),
    .kind_o     (kind_b)
  );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            iss_valid,
  input logic [IDX_W-1:0]                iss_src_a,
  input logic [IDX_W-1:0]                iss_dst,
  input logic [TAG_W-1:0]                iss_tag,
  input logic                            bus_valid,
  input logic [TAG_W-1:0]                bus_tag,
  input logic [DATA_W-1:0]               bus_data,
  input logic [DATA_W-1:0]               rd_a_val,
  input logic [TAG_W-1:0]                rd_a_tag,
  input src_kind_e                       kind_a,
  input logic [NUM_REGS-1:0]             rename_vec,
  input logic [NUM_REGS-1:0]             bus_hit_vec,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_tbl,
  input logic [NUM_REGS-1:0][DATA_W-1:0] val_tbl
);

  logic             issue_ok;
  logic             bus_any;
  logic [TAG_W-1:0] cur_a_tag;

  assign issue_ok  = iss_valid && (iss_tag != '0);
  assign bus_any   = bus_valid && (bus_tag != '0);
  assign cur_a_tag = tag_tbl[iss_src_a];

  assert_reset_blank_R1: assert property (@(posedge clk)
    !rst_n |=> (tag_tbl == '0) && (val_tbl == '0));

  assert_pending_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_a_tag != '0) && !(bus_any && cur_a_tag == bus_tag)
      |-> (rd_a_tag == cur_a_tag) && (rd_a_val == '0) && (kind_a == SRC_PENDING));

  assert_rename_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> tag_tbl[$past(iss_dst)] == $past(iss_tag));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_ok && !bus_any) |=> $stable(tag_tbl) && $stable(val_tbl));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_any && cur_a_tag == bus_tag)
      |-> (rd_a_tag == '0) && (rd_a_val == bus_data));

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit_vec[k] && !rename_vec[k])
          |=> (tag_tbl[k] == '0) && (val_tbl[k] == $past(bus_data)));

      assert_rename_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit_vec[k] && rename_vec[k]) |=> tag_tbl[k] == $past(iss_tag));

      assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_vec[k] && !bus_hit_vec[k]) |=> $stable(tag_tbl[k]));
    end
  endgenerate

endmodule

bind rename_status_table rrs_checker #(
  .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_src_a  (iss_src_a),
  .iss_dst    (iss_dst),
  .iss_tag    (iss_tag),
  .bus_valid  (bus_valid),
  .bus_tag    (bus_tag),
  .bus_data   (bus_data),
  .rd_a_val   (rd_a_val),
  .rd_a_tag   (rd_a_tag),
  .kind_a     (kind_a),
  .rename_vec (rename_vec),
  .bus_hit_vec(bus_hit_vec),
  .tag_tbl    (tag_tbl),
  .val_tbl    (val_tbl)
);

// File: tb/rename_status_table_test.sv
module rename_status_table_test;

  localparam int NR = 8;
  localparam int TW = 4;
  localparam int DW = 64;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [IW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [TW-1:0] iss_tag = '0;
  logic          bus_valid = 1'b0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_data = '0;
  logic [DW-1:0] rd_a_val, rd_b_val;
  logic [TW-1:0] rd_a_tag, rd_b_tag;

  int total = 0;
  int bad   = 0;

  logic [TW-1:0] m_tag [NR];
  logic [DW-1:0] m_val [NR];

  always #5 clk = ~clk;

  rename_status_table uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag), .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag)
  );

  // Model: is the source's producer on the bus right now
  function automatic logic on_bus(input int src);
    return bus_valid && (bus_tag != 0) && (m_tag[src] == bus_tag);
  endfunction

  function automatic logic [TW-1:0] want_tag(input int src);
    if (m_tag[src] == 0 || on_bus(src)) return '0;
    return m_tag[src];
  endfunction

  function automatic logic [DW-1:0] want_val(input int src);
    if (m_tag[src] == 0) return m_val[src];
    if (on_bus(src))     return bus_data;
    return '0;
  endfunction

  function automatic string auto_label(input int src);
    if (iss_valid && iss_tag != 0 && src == int'(iss_dst)) return "R10";
    if (m_tag[src] == 0) return "R2";
    if (on_bus(src))     return "R8";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model update at the clock edge: bus match first, then rename on top
  task automatic model_edge();
    logic hit [NR];
    for (int r = 0; r < NR; r++) hit[r] = on_bus(r);
    for (int r = 0; r < NR; r++) begin
      if (hit[r]) begin
        m_val[r] = bus_data;
        m_tag[r] = '0;
      end
    end
    if (iss_valid && iss_tag != 0) m_tag[iss_dst] = iss_tag;
  endtask

  // One cycle: drive at the falling edge, check the combinational reads, clock
  task automatic cyc(input logic iv, input int sa, input int sb, input int d,
                     input int it, input logic bv, input int bt,
                     input logic [DW-1:0] bd, input string lab);
    string la, lb;
    iss_valid = iv; iss_src_a = IW'(sa); iss_src_b = IW'(sb); iss_dst = IW'(d);
    iss_tag = TW'(it); bus_valid = bv; bus_tag = TW'(bt); bus_data = bd;
    #1;
    la = (lab != "") ? lab : auto_label(sa);
    lb = (lab != "") ? lab : auto_label(sb);
    check({la, " a.tag"}, DW'(rd_a_tag), DW'(want_tag(sa)));
    check({la, " a.val"}, rd_a_val, want_val(sa));
    check({lb, " b.tag"}, DW'(rd_b_tag), DW'(want_tag(sb)));
    check({lb, " b.val"}, rd_b_val, want_val(sb));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_read(input int r, input string lab);
    cyc(1'b0, r, r, 0, 0, 1'b0, 0, '0, lab);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    for (int r = 0; r < NR; r++) begin m_tag[r] = '0; m_val[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: after reset every register reads value 0, tag 0
    for (int r = 0; r < NR; r++) idle_read(r, "R1");

    // R4: rename then overwrite (WAW), newest tag visible
    cyc(1'b1, 0, 0, 3, 5, 1'b0, 0, '0, "");
    cyc(1'b1, 0, 0, 3, 7, 1'b0, 0, '0, "");
    idle_read(3, "R4");
    // R5: broadcast of the stale tag 5 must not touch reg 3; tag 7 completes it
    cyc(1'b0, 0, 0, 0, 0, 1'b1, 5, 64'h1111, "");
    idle_read(3, "R5");
    cyc(1'b0, 0, 0, 0, 0, 1'b1, 7, 64'hABCD_0123_4567_89EF, "");
    idle_read(3, "R5");

    // R6: invalid bus or zero tag changes nothing
    cyc(1'b1, 0, 0, 1, 2, 1'b0, 0, '0, "");
    cyc(1'b0, 1, 1, 0, 0, 1'b0, 2, 64'hDEAD, "R6");
    cyc(1'b0, 0, 0, 0, 0, 1'b1, 0, 64'hBEEF, "");
    idle_read(1, "R6");
    idle_read(0, "R6");

    // R9: issue with valid low or tag zero leaves reg 4 blank
    cyc(1'b1, 0, 0, 4, 0, 1'b0, 0, '0, "");
    cyc(1'b0, 0, 0, 4, 6, 1'b0, 0, '0, "");
    idle_read(4, "R9");

    // R7: reg 1 cleared by tag 2 while renamed to tag 11 in the same cycle
    cyc(1'b1, 0, 0, 1, 11, 1'b1, 2, 64'h7777, "");
    idle_read(1, "R7");

    // R8: read reg 1 while its producer 11 broadcasts
    cyc(1'b0, 1, 1, 0, 0, 1'b1, 11, 64'h0000_5555_AAAA_0001, "R8");
    idle_read(1, "R8");

    // R10: reg 5 pending on 3; issue renames it to 4 and reads it
    cyc(1'b1, 0, 0, 5, 3, 1'b0, 0, '0, "");
    cyc(1'b1, 5, 5, 5, 4, 1'b0, 0, '0, "R10");
    idle_read(5, "R10");

    // Random traffic, bus tag usually taken from a live entry
    for (int n = 0; n < 4000; n++) begin
      int  pick;
      int  bt;
      pick = int'($urandom_range(NR - 1));
      bt = ($urandom_range(3) != 0) ? int'(m_tag[pick]) : int'($urandom_range(15));
      cyc(($urandom_range(1) == 1), int'($urandom_range(NR - 1)), int'($urandom_range(NR - 1)),
          int'($urandom_range(NR - 1)), int'($urandom_range(15)),
          ($urandom_range(4) > 1), bt, {$urandom, $urandom}, "");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule